// File: doc/BRIEF.md
# UART Interrupt Flag Controller

This block sits next to the serial datapath of a UART with LIN support. It holds every status flag that can raise an interrupt, applies the set and clear rule that belongs to each flag, and drives three interrupt lines: receive, transmit, and LIN/idle. The datapath reports single-cycle event pulses: word received, FIFO trigger level reached, framing error, parity error, LIN break, bus idle, receive activity, transmit activity, and transmit holding register moved to the shifter.

The CPU reaches the block through a plain register bus. A strobe is `bus_sel` with `bus_wr` or `bus_rd` high for one cycle; writes take effect at the next clock edge. Reads return data in the same cycle. The bus has no wait states and no back-pressure, so every strobe is accepted in the cycle it is presented. The block does not buffer data. A read of the receive data address passes `rx_data_i` through and pulses `rx_read_o` so the FIFO can pop. A write to the transmit data address presents `tx_data_o` with a `tx_load_o` pulse in the same cycle.

Register map (addresses in `bus_addr`):
- 0: receive data, read.
- 1: transmit data, write.
- 2: status, read.
- 3: control, read/write.
- 4: error clear, write.
- 5: LIN status, read/write.

Status bits:
- bit0: receive ready
- bit1: overrun
- bit2: framing error
- bit3: parity error
- bit4: transmit empty
- bit5: LIN break
- bit6: receive idle
- bit7: transmit idle

Control bits:
- bit0: receive interrupt enable
- bit1: transmit interrupt enable
- bit2: LIN break interrupt enable
- bit3: idle interrupt enable
- bit4: FIFO mode
- bit5: start/stop framing in synchronous mode
- bits[7:6]: operating mode, where 2 selects synchronous

Top module: `uart_irq_flags`

## Requirements
- R1: After reset, status reads 0x10 (only transmit empty set), control reads 0x00, and all three interrupt lines are 0.
- R2: Receive ready (status bit0) sets on a received-word pulse when control bit4 is 0. It sets on a FIFO-trigger pulse, and not on a word pulse, when control bit4 is 1.
- R3: A read of address 0 returns `rx_data_i` on `bus_rdata`, pulses `rx_read_o`, and clears receive ready.
- R4: Overrun (status bit1) sets when a word pulse arrives while receive ready is 1 and address 0 is not being read in that cycle.
- R5: Overrun, framing error (bit2) and parity error (bit3) are left unchanged by reads. They clear only when a write to address 4 has wdata bit0 = 1. A framing pulse is ignored when the mode is 2 and control bit5 is 0.
- R6: LIN break (status bit5, also address 5 bit0) sets on a break pulse. Writing 0 to address 5 bit0 clears it; writing 1 leaves it unchanged.
- R7: A bus-idle pulse sets receive idle (bit6) and transmit idle (bit7). A receive-activity pulse clears bit6, and a transmit-activity pulse clears bit7.
- R8: Transmit empty (bit4) sets on a holding-to-shifter transfer pulse and clears on a write to address 1.
- R9: When a set event and a clear action hit the same flag in one cycle, the flag ends up 1.
- R10: `irq_rx` is control bit0 AND (any of status bits 0 to 3). `irq_tx` is control bit1 AND transmit empty. `irq_lin` is (control bit2 AND LIN break) OR (control bit3 AND (receive idle OR transmit idle)).
- R11: A write to address 1 drives `bus_wdata` onto `tx_data_o` with `tx_load_o` high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| rx_data_i | input | DATA_W | Head word from the receive path |
| rx_read_o | output | 1 | Pulse: receive data register read |
| tx_data_o | output | DATA_W | Transmit word for the holding register |
| tx_load_o | output | 1 | Pulse: transmit word written |
| ev_rx_word | input | 1 | Received word loaded |
| ev_fifo_trig | input | 1 | FIFO fill reached trigger level |
| ev_frame_err | input | 1 | Framing error seen |
| ev_parity_err | input | 1 | Parity error seen |
| ev_lin_break | input | 1 | LIN sync break detected |
| ev_bus_idle | input | 1 | No reception and no transmission |
| ev_rx_active | input | 1 | Reception activity resumed |
| ev_tx_active | input | 1 | Transmission activity resumed |
| ev_tx_xfer | input | 1 | Holding register moved to shifter |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_lin | output | 1 | LIN break / idle interrupt |

## Verification
The hardest cases to reach from the ports are same-cycle collisions. One is a CPU clear arriving in the same clock as a datapath event for the same flag. Another is a new word landing in the very cycle its predecessor is read, which must not count as an overrun. The stimulus table carries a bus operation and an event vector in the same row, so these collisions are produced by placing both in one row. The status register is then read back before the next row is applied.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int ADDR_W = 3;
  localparam int CSR_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_RXDATA  = 3'd0,
    A_TXDATA  = 3'd1,
    A_STATUS  = 3'd2,
    A_CTRL    = 3'd3,
    A_ERRCLR  = 3'd4,
    A_LINSTAT = 3'd5
  } addr_e;

  typedef enum logic [1:0] {
    M_ASYNC = 2'd0,
    M_MULTI = 2'd1,
    M_SYNC  = 2'd2,
    M_LIN   = 2'd3
  } mode_e;

  // Packed MSB first: mode sits in bits [7:6]
  typedef struct packed {
    logic [1:0] mode;
    logic       sync_ss;
    logic       fifo_en;
    logic       idle_ie;
    logic       lin_ie;
    logic       tx_ie;
    logic       rx_ie;
  } ctrl_t;

  typedef struct packed {
    logic txi;
    logic rxi;
    logic lbd;
    logic txe;
    logic par;
    logic fre;
    logic ovr;
    logic rdy;
  } status_t;

endpackage

// File: rtl/uirq_flag.sv
module uirq_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= RST_VAL;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // Set takes priority over a clear in the same cycle
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q));

endmodule

// File: rtl/uirq_regif.sv
module uirq_regif
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_data,
  input  status_t           status,
  output ctrl_t             ctrl,
  output logic              rd_rx,
  output logic              wr_tx,
  output logic              clr_err,
  output logic              lbd_clr
);

  localparam int PAD_W = DATA_W - CSR_W;

  logic wr_any, rd_any;
  assign wr_any = bus_sel && bus_wr;
  assign rd_any = bus_sel && bus_rd;

  assign rd_rx   = rd_any && (bus_addr == A_RXDATA);
  assign wr_tx   = wr_any && (bus_addr == A_TXDATA);
  assign clr_err = wr_any && (bus_addr == A_ERRCLR)  &&  bus_wdata[0];
  assign lbd_clr = wr_any && (bus_addr == A_LINSTAT) && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_any && (bus_addr == A_CTRL))
      ctrl <= ctrl_t'(bus_wdata[CSR_W-1:0]);
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        unique case (bus_addr)
          A_RXDATA:  bus_rdata = rx_data;
          A_STATUS:  bus_rdata = {{PAD_W{1'b0}}, status};
          A_CTRL:    bus_rdata = {{PAD_W{1'b0}}, ctrl};
          A_LINSTAT: bus_rdata = {{(DATA_W-1){1'b0}}, status.lbd};
          default:   bus_rdata = '0;
        endcase
      end
    end else begin : g_nopad
      always_comb begin
        unique case (bus_addr)
          A_RXDATA:  bus_rdata = rx_data;
          A_STATUS:  bus_rdata = status;
          A_CTRL:    bus_rdata = ctrl;
          A_LINSTAT: bus_rdata = {{(DATA_W-1){1'b0}}, status.lbd};
          default:   bus_rdata = '0;
        endcase
      end
    end
  endgenerate

  // Strobes for distinct addresses never coincide
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_rx, wr_tx, clr_err, lbd_clr}));

endmodule

// File: rtl/uirq_rx_flags.sv
module uirq_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_word,
  input  logic ev_trig,
  input  logic ev_fre,
  input  logic ev_par,
  input  logic fifo_en,
  input  logic fre_en,
  input  logic rd_rx,
  input  logic clr_err,
  output logic rdy,
  output logic ovr,
  output logic fre,
  output logic par
);

  localparam int NFLAG = 4;

  logic [NFLAG-1:0] set_v, clr_v, q_v;

  // Ready source chosen by mode; overrun only when unread data is replaced
  assign set_v[0] = fifo_en ? ev_trig : ev_word;
  assign set_v[1] = ev_word && rdy && !rd_rx;
  assign set_v[2] = ev_fre && fre_en;
  assign set_v[3] = ev_par;

  assign clr_v[0] = rd_rx;
  assign clr_v[1] = clr_err;
  assign clr_v[2] = clr_err;
  assign clr_v[3] = clr_err;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    uirq_flag #(.RST_VAL(1'b0)) u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_v[i]),
      .clr  (clr_v[i]),
      .q    (q_v[i])
    );
  end

  assign rdy = q_v[0];
  assign ovr = q_v[1];
  assign fre = q_v[2];
  assign par = q_v[3];

  p_ovr_needs_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rdy));
  p_fre_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fre) |-> $past(fre_en));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_err) |=> ovr);

endmodule

// File: rtl/uirq_aux_flags.sv
module uirq_aux_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_break,
  input  logic ev_idle,
  input  logic ev_rx_act,
  input  logic ev_tx_act,
  input  logic ev_xfer,
  input  logic lbd_clr,
  input  logic wr_tx,
  output logic lbd,
  output logic rxi,
  output logic txi,
  output logic txe
);

  uirq_flag #(.RST_VAL(1'b0)) u_lbd (
    .clk(clk), .rst_n(rst_n), .set(ev_break), .clr(lbd_clr), .q(lbd));

  uirq_flag #(.RST_VAL(1'b0)) u_rxi (
    .clk(clk), .rst_n(rst_n), .set(ev_idle), .clr(ev_rx_act), .q(rxi));

  uirq_flag #(.RST_VAL(1'b0)) u_txi (
    .clk(clk), .rst_n(rst_n), .set(ev_idle), .clr(ev_tx_act), .q(txi));

  // Holding register starts empty
  uirq_flag #(.RST_VAL(1'b1)) u_txe (
    .clk(clk), .rst_n(rst_n), .set(ev_xfer), .clr(wr_tx), .q(txe));

  p_idle_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle |=> (rxi && txi));
  p_txe_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txe) |-> $past(wr_tx));

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_read_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_load_o,
  input  logic              ev_rx_word,
  input  logic              ev_fifo_trig,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_lin_break,
  input  logic              ev_bus_idle,
  input  logic              ev_rx_active,
  input  logic              ev_tx_active,
  input  logic              ev_tx_xfer,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_lin
);

  ctrl_t   ctrl;
  status_t status;
  logic    rd_rx, wr_tx, clr_err, lbd_clr, fre_en;

  uirq_regif #(.DATA_W(DATA_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rx_data  (rx_data_i),
    .status   (status),
    .ctrl     (ctrl),
    .rd_rx    (rd_rx),
    .wr_tx    (wr_tx),
    .clr_err  (clr_err),
    .lbd_clr  (lbd_clr)
  );

  // Framing check is off in synchronous mode unless start/stop framing is used
  assign fre_en = (ctrl.mode != M_SYNC) || ctrl.sync_ss;

  uirq_rx_flags u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_word(ev_rx_word),
    .ev_trig(ev_fifo_trig),
    .ev_fre (ev_frame_err),
    .ev_par (ev_parity_err),
    .fifo_en(ctrl.fifo_en),
    .fre_en (fre_en),
    .rd_rx  (rd_rx),
    .clr_err(clr_err),
    .rdy    (status.rdy),
    .ovr    (status.ovr),
    .fre    (status.fre),
    .par    (status.par)
  );

  uirq_aux_flags u_aux (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_break (ev_lin_break),
    .ev_idle  (ev_bus_idle),
    .ev_rx_act(ev_rx_active),
    .ev_tx_act(ev_tx_active),
    .ev_xfer  (ev_tx_xfer),
    .lbd_clr  (lbd_clr),
    .wr_tx    (wr_tx),
    .lbd      (status.lbd),
    .rxi      (status.rxi),
    .txi      (status.txi),
    .txe      (status.txe)
  );

  assign rx_read_o = rd_rx;
  assign tx_load_o = wr_tx;
  assign tx_data_o = bus_wdata;

  assign irq_rx  = ctrl.rx_ie && (status.rdy || status.ovr || status.fre || status.par);
  assign irq_tx  = ctrl.tx_ie && status.txe;
  assign irq_lin = (ctrl.lin_ie && status.lbd) ||
                   (ctrl.idle_ie && (status.rxi || status.txi));

  p_irq_rx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> ctrl.rx_ie);
  p_irq_tx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> status.txe);
  p_rdy_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_word && !ctrl.fifo_en) |=> status.rdy);

endmodule

// File: tb/uart_irq_flags_tb.sv
module uart_irq_flags_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NSTEP = 31;
  localparam int VW = 33;

  // row: op[32:31] (0 none,1 wr,2 rd) addr[30:28] wdata[27:20] ev[19:11] st[10:3] irq[2:0]
  // ev bits: 0 word,1 trig,2 frame,3 parity,4 break,5 idle,6 rxact,7 txact,8 xfer
  // irq bits: {lin, tx, rx}
  localparam logic [VW-1:0] TBL [NSTEP] = '{
    {2'd0, 3'd0, 8'h00, 9'h000, 8'h10, 3'b000}, // R1 reset
    {2'd1, 3'd3, 8'h0F, 9'h000, 8'h10, 3'b010}, // R10 enables
    {2'd0, 3'd0, 8'h00, 9'h001, 8'h11, 3'b011}, // R2 word
    {2'd0, 3'd0, 8'h00, 9'h001, 8'h13, 3'b011}, // R4 overrun
    {2'd2, 3'd0, 8'h00, 9'h000, 8'h12, 3'b011}, // R3 read clears rdy, R5 ovr stays
    {2'd1, 3'd4, 8'h01, 9'h000, 8'h10, 3'b010}, // R5 clear err
    {2'd1, 3'd1, 8'h55, 9'h000, 8'h00, 3'b000}, // R8 tx write
    {2'd0, 3'd0, 8'h00, 9'h100, 8'h10, 3'b010}, // R8 xfer
    {2'd0, 3'd0, 8'h00, 9'h010, 8'h30, 3'b110}, // R6 break
    {2'd1, 3'd5, 8'h01, 9'h000, 8'h30, 3'b110}, // R6 write 1 no effect
    {2'd1, 3'd5, 8'h00, 9'h000, 8'h10, 3'b010}, // R6 write 0 clears
    {2'd0, 3'd0, 8'h00, 9'h020, 8'hD0, 3'b110}, // R7 idle
    {2'd0, 3'd0, 8'h00, 9'h040, 8'h90, 3'b110}, // R7 rx act
    {2'd0, 3'd0, 8'h00, 9'h080, 8'h10, 3'b010}, // R7 tx act
    {2'd0, 3'd0, 8'h00, 9'h00C, 8'h1C, 3'b011}, // R5 frame+parity
    {2'd1, 3'd4, 8'h01, 9'h008, 8'h18, 3'b011}, // R9 parity vs clear
    {2'd1, 3'd4, 8'h01, 9'h000, 8'h10, 3'b010}, // R5 clear
    {2'd1, 3'd3, 8'h8F, 9'h000, 8'h10, 3'b010}, // sync mode, no ss
    {2'd0, 3'd0, 8'h00, 9'h004, 8'h10, 3'b010}, // R5 frame ignored
    {2'd1, 3'd3, 8'hAF, 9'h000, 8'h10, 3'b010}, // sync with ss
    {2'd0, 3'd0, 8'h00, 9'h004, 8'h14, 3'b011}, // R5 frame accepted
    {2'd1, 3'd4, 8'h01, 9'h000, 8'h10, 3'b010}, // R5 clear
    {2'd1, 3'd3, 8'h1F, 9'h000, 8'h10, 3'b010}, // FIFO mode
    {2'd0, 3'd0, 8'h00, 9'h001, 8'h10, 3'b010}, // R2 word ignored in FIFO
    {2'd0, 3'd0, 8'h00, 9'h002, 8'h11, 3'b011}, // R2 trigger
    {2'd2, 3'd0, 8'h00, 9'h002, 8'h11, 3'b011}, // R9 read vs trigger
    {2'd2, 3'd0, 8'h00, 9'h000, 8'h10, 3'b010}, // R3 read
    {2'd1, 3'd3, 8'h00, 9'h000, 8'h10, 3'b000}, // R10 disable all
    {2'd0, 3'd0, 8'h00, 9'h001, 8'h11, 3'b000}, // R10 masked
    {2'd1, 3'd1, 8'h22, 9'h100, 8'h11, 3'b000}, // R9 xfer vs tx write
    {2'd2, 3'd0, 8'h00, 9'h001, 8'h11, 3'b000}  // R4 read+word no overrun
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, rx_data_i = '0;
  logic [DW-1:0] bus_rdata, tx_data_o;
  logic          rx_read_o, tx_load_o, irq_rx, irq_tx, irq_lin;
  logic [8:0]    ev = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_flags #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data_i(rx_data_i), .rx_read_o(rx_read_o),
    .tx_data_o(tx_data_o), .tx_load_o(tx_load_o),
    .ev_rx_word(ev[0]), .ev_fifo_trig(ev[1]), .ev_frame_err(ev[2]),
    .ev_parity_err(ev[3]), .ev_lin_break(ev[4]), .ev_bus_idle(ev[5]),
    .ev_rx_active(ev[6]), .ev_tx_active(ev[7]), .ev_tx_xfer(ev[8]),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_lin(irq_lin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle_drive();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic peek(input logic [2:0] a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a; bus_wdata = '0;
    #1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_idle_drive();
  endtask

  task automatic run_row(input logic [VW-1:0] r, input int idx);
    logic [1:0] op;
    op = r[32:31];
    @(negedge clk);
    bus_sel = (op != 2'd0); bus_wr = (op == 2'd1); bus_rd = (op == 2'd2);
    bus_addr = r[30:28]; bus_wdata = r[27:20]; ev = r[19:11];
    @(posedge clk); #1;
    ev = '0;
    peek(3'd2);
    check($sformatf("row %0d status (R1-R10 table)", idx), {24'd0, bus_rdata}, {24'd0, r[10:3]});
    check($sformatf("row %0d irq R10", idx), {29'd0, irq_lin, irq_tx, irq_rx}, {29'd0, r[2:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) run_row(TBL[i], i);

    // R3: read path passes data and pulses rx_read_o
    @(negedge clk);
    bus_idle_drive();
    rx_data_i = 8'hA5;
    peek(3'd0);
    check("R3 rdata", {24'd0, bus_rdata}, 32'hA5);
    check("R3 rx_read_o", {31'd0, rx_read_o}, 32'd1);
    @(negedge clk);
    bus_idle_drive();

    // R11: transmit write presents data and load pulse
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h3C;
    #1;
    check("R11 tx_data_o", {24'd0, tx_data_o}, 32'h3C);
    check("R11 tx_load_o", {31'd0, tx_load_o}, 32'd1);
    @(posedge clk); #1;
    bus_idle_drive();
    #1;
    check("R11 tx_load_o idle", {31'd0, tx_load_o}, 32'd0);

    // R6: LIN status address mirrors break flag
    @(negedge clk) ev = 9'h010;
    @(posedge clk); #1 ev = '0;
    peek(3'd5);
    check("R6 linstat read", {24'd0, bus_rdata}, 32'd1);

    // R1: reset mid-run restores defaults
    bus_write(3'd3, 8'hFF);
    peek(3'd3);
    check("R1 ctrl before reset", {24'd0, bus_rdata}, 32'hFF);
    @(negedge clk);
    bus_idle_drive();
    rst_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk) rst_n = 1'b1;
    peek(3'd2);
    check("R1 status after reset", {24'd0, bus_rdata}, 32'h10);
    peek(3'd3);
    check("R1 ctrl after reset", {24'd0, bus_rdata}, 32'h00);
    check("R1 irqs after reset", {29'd0, irq_lin, irq_tx, irq_rx}, 32'd0);
    bus_idle_drive();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule